// File: doc/BRIEF.md
# Clock-Mode Delay PHY Sequencer

This block reprograms the delay settings of a storage-card interface PHY each time the card clock or the bus speed mode changes. A one-cycle start pulse captures the speed-mode code, the target clock in MHz and the per-mode tap, strobe, trim, drive and buffer values. The block then writes the PHY control fields, one step per clock, in a fixed order.

The block picks one of two delay sources. Fast modes at 50 MHz or more use a locked DLL: the block programs the frequency range, the trim and the drive strength, enables the DLL and waits for its ready bit, with a cycle timeout. Every other case uses the open delay chain: the DLL stays off, the chain select bits are set and the input tap is loaded inside an open change window. Both paths end by loading the clock-buffer select. The block then pulses done, or pulses error if the lock timed out.

Top module: `dlyphy_seq`

## Requirements
- R1: After a synchronous reset, every output is 0 and `busy` is low.
- R2: The clock edge that accepts `start` in idle clears `dll_en`, and no other control field changes on that edge.
- R3: On the second edge of a sequence, `otap_en` becomes 1 exactly when the mode code is above 4 (codes 0..4 are the slow modes, 5..10 the fast ones) and `otap_sel` takes the captured 4-bit tap.
- R4: The DLL path is taken only when the mode code is above 4 and `clk_mhz` is at least 50. The DLL path clears `dly_tx_sel` and `dly_rx_sel` on the third edge, and the chain path sets both on that edge.
- R5: On the DLL path, the frequency fields are written on the fourth edge and the 4-bit trim and 3-bit drive on the fifth. `dll_en` rises on the sixth edge, never while a chain select bit is set.
- R6: With the 2-bit frequency variant (FREQ_2BIT=1), 200 MHz gives sel50=0 and sel100=0, 100 MHz gives sel50=0 and sel100=1, and any other clock gives sel50=1 and sel100=0. `freq_code` stays 0.
- R7: With the 3-bit variant (FREQ_2BIT=0), 200 MHz gives `freq_code`=0 and any other clock gives 4. sel50 and sel100 stay 0.
- R8: While waiting for lock, a high `dll_ready` moves the sequence on to its final step. If `dll_ready` stays low for TIMEOUT_CYC cycles, `err` pulses for one cycle, the block returns to idle and `clkbuf_sel` is left unchanged.
- R9: On the chain path, `dll_en` stays 0 and `itap_win` opens for one cycle before `itap_sel` is loaded. The window closes one cycle after the load, and `itap_sel` never changes while the window is closed.
- R10: Only mode code 10 (the strobe mode) loads `strobe_sel`, whose width is STRB_W (4 or 8). Other modes leave it unchanged.
- R11: `clkbuf_sel` is written as the last step of a successful sequence, together with a one-cycle `done` pulse, and `busy` falls on the same edge.
- R12: A `start` pulse while `busy` is high is ignored, and the sequence in progress continues with the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reconfiguration sequence |
| mode | input | 4 | Speed-mode code, 0..10 |
| clk_mhz | input | MHZ_W | Target card clock in MHz |
| otap_in | input | 4 | Output tap for this mode |
| itap_in | input | 5 | Input tap for this mode |
| strobe_in | input | STRB_W | Strobe select for the strobe mode |
| trim_in | input | 4 | DLL charge-pump trim |
| drive_in | input | 3 | DLL drive-strength code |
| clkbuf_in | input | 3 | Clock-buffer select |
| dll_ready | input | 1 | DLL lock status from the PHY |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse, sequence completed |
| err | output | 1 | One-cycle pulse, DLL lock timeout |
| otap_en | output | 1 | Output tap enable |
| otap_sel | output | 4 | Output tap select |
| strobe_sel | output | STRB_W | Strobe select |
| dll_en | output | 1 | DLL enable |
| freq_sel50 | output | 1 | 2-bit variant low-range select |
| freq_sel100 | output | 1 | 2-bit variant mid-range select |
| freq_code | output | 3 | 3-bit variant frequency code |
| dll_trim | output | 4 | DLL trim |
| drive_str | output | 3 | DLL drive strength |
| dly_tx_sel | output | 1 | Transmit delay-chain select |
| dly_rx_sel | output | 1 | Receive delay-chain select |
| itap_win | output | 1 | Input tap change window |
| itap_sel | output | 5 | Input tap select |
| clkbuf_sel | output | 3 | Clock-buffer select |

## Verification
A wrong state register or a wrong path choice shows at the ports within one clock: a field changes on the wrong edge, or the wrong path's fields move. The bench compares every output against its reference on every cycle, so a single misplaced write is caught at the cycle where it happens. A wrong lock counter shows as an `err` pulse that comes too early or too late, or as a missing `done`. A bad capture of the inputs, or a restart while busy, shows as changed field values in the middle of a sequence. Both frequency variants run side by side on the same stimulus, so a wrong encoding is seen on the edge that writes the frequency fields.

// File: rtl/dlyphy_pkg.sv
package dlyphy_pkg;
  localparam int MODE_W    = 4;
  localparam int OTAP_W    = 4;
  localparam int ITAP_W    = 5;
  localparam int TRIM_W    = 4;
  localparam int DRV_W     = 3;
  localparam int CBUF_W    = 3;
  localparam int FCODE_W   = 3;

  localparam logic [MODE_W-1:0] MODE_SLOW_MAX = 4'd4;
  localparam logic [MODE_W-1:0] MODE_STROBE   = 4'd10;

  localparam int MHZ_FULL    = 200;
  localparam int MHZ_HALF    = 100;
  localparam int MHZ_DLL_MIN = 50;

  localparam logic [FCODE_W-1:0] FCODE_FULL  = 3'd0;
  localparam logic [FCODE_W-1:0] FCODE_OTHER = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OTAP, ST_DSEL, ST_FREQ, ST_TRIM, ST_DLLON, ST_WAIT,
    ST_CSEL, ST_WOPEN, ST_IWR, ST_WCLOSE, ST_CBUF
  } seq_st_t;
endpackage

// File: rtl/dlyphy_mode_dec.sv
module dlyphy_mode_dec
  import dlyphy_pkg::*;
#(
  parameter int FREQ_2BIT = 1,
  parameter int MHZ_W     = 10
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [MHZ_W-1:0]   mhz,
  output logic               otap_on,
  output logic               use_dll,
  output logic               strobe_mode,
  output logic               sel50,
  output logic               sel100,
  output logic [FCODE_W-1:0] fcode
);
  logic is_full, is_half;

  assign is_full     = (mhz == MHZ_W'(MHZ_FULL));
  assign is_half     = (mhz == MHZ_W'(MHZ_HALF));
  assign otap_on     = (mode > MODE_SLOW_MAX);
  assign use_dll     = otap_on && (mhz >= MHZ_W'(MHZ_DLL_MIN));
  assign strobe_mode = (mode == MODE_STROBE);

  generate
    if (FREQ_2BIT != 0) begin : g_two_bit
      assign sel50  = !(is_full || is_half);
      assign sel100 = is_half;
      assign fcode  = '0;
    end else begin : g_three_bit
      assign sel50  = 1'b0;
      assign sel100 = 1'b0;
      assign fcode  = is_full ? FCODE_FULL : FCODE_OTHER;
    end
  endgenerate
endmodule

// File: rtl/dlyphy_lock_timer.sv
module dlyphy_lock_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
    else                      cnt <= '0;
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(LIMIT));
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);
endmodule

// File: rtl/dlyphy_seq.sv
module dlyphy_seq
  import dlyphy_pkg::*;
#(
  parameter int FREQ_2BIT   = 1,
  parameter int STRB_W      = 4,
  parameter int TIMEOUT_CYC = 1000,
  parameter int MHZ_W       = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [3:0]          mode,
  input  logic [MHZ_W-1:0]    clk_mhz,
  input  logic [3:0]          otap_in,
  input  logic [4:0]          itap_in,
  input  logic [STRB_W-1:0]   strobe_in,
  input  logic [3:0]          trim_in,
  input  logic [2:0]          drive_in,
  input  logic [2:0]          clkbuf_in,
  input  logic                dll_ready,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                otap_en,
  output logic [3:0]          otap_sel,
  output logic [STRB_W-1:0]   strobe_sel,
  output logic                dll_en,
  output logic                freq_sel50,
  output logic                freq_sel100,
  output logic [2:0]          freq_code,
  output logic [3:0]          dll_trim,
  output logic [2:0]          drive_str,
  output logic                dly_tx_sel,
  output logic                dly_rx_sel,
  output logic                itap_win,
  output logic [4:0]          itap_sel,
  output logic [2:0]          clkbuf_sel
);
  seq_st_t st;

  logic [MODE_W-1:0] mode_q;
  logic [MHZ_W-1:0]  mhz_q;
  logic [OTAP_W-1:0] otap_q;
  logic [ITAP_W-1:0] itap_q;
  logic [STRB_W-1:0] strb_q;
  logic [TRIM_W-1:0] trim_q;
  logic [DRV_W-1:0]  drv_q;
  logic [CBUF_W-1:0] cbuf_q;

  logic otap_on, use_dll, strobe_mode, dec_sel50, dec_sel100;
  logic [FCODE_W-1:0] dec_fcode;
  logic lock_expired;

  dlyphy_mode_dec #(.FREQ_2BIT(FREQ_2BIT), .MHZ_W(MHZ_W)) u_dec (
    .mode(mode_q), .mhz(mhz_q), .otap_on(otap_on), .use_dll(use_dll),
    .strobe_mode(strobe_mode), .sel50(dec_sel50), .sel100(dec_sel100),
    .fcode(dec_fcode)
  );

  dlyphy_lock_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(st == ST_WAIT), .expired(lock_expired)
  );

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    err  <= 1'b0;
    if (rst) begin
      st          <= ST_IDLE;
      mode_q      <= '0;
      mhz_q       <= '0;
      otap_q      <= '0;
      itap_q      <= '0;
      strb_q      <= '0;
      trim_q      <= '0;
      drv_q       <= '0;
      cbuf_q      <= '0;
      otap_en     <= 1'b0;
      otap_sel    <= '0;
      strobe_sel  <= '0;
      dll_en      <= 1'b0;
      freq_sel50  <= 1'b0;
      freq_sel100 <= 1'b0;
      freq_code   <= '0;
      dll_trim    <= '0;
      drive_str   <= '0;
      dly_tx_sel  <= 1'b0;
      dly_rx_sel  <= 1'b0;
      itap_win    <= 1'b0;
      itap_sel    <= '0;
      clkbuf_sel  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          mode_q <= mode;
          mhz_q  <= clk_mhz;
          otap_q <= otap_in;
          itap_q <= itap_in;
          strb_q <= strobe_in;
          trim_q <= trim_in;
          drv_q  <= drive_in;
          cbuf_q <= clkbuf_in;
          dll_en <= 1'b0;
          st     <= ST_OTAP;
        end
        ST_OTAP: begin
          otap_en  <= otap_on;
          otap_sel <= otap_q;
          if (strobe_mode) strobe_sel <= strb_q;
          st <= use_dll ? ST_DSEL : ST_CSEL;
        end
        ST_DSEL: begin
          dly_tx_sel <= 1'b0;
          dly_rx_sel <= 1'b0;
          st         <= ST_FREQ;
        end
        ST_FREQ: begin
          freq_sel50  <= dec_sel50;
          freq_sel100 <= dec_sel100;
          freq_code   <= dec_fcode;
          st          <= ST_TRIM;
        end
        ST_TRIM: begin
          dll_trim  <= trim_q;
          drive_str <= drv_q;
          st        <= ST_DLLON;
        end
        ST_DLLON: begin
          dll_en <= 1'b1;
          st     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (dll_ready) st <= ST_CBUF;
          else if (lock_expired) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end
        end
        ST_CSEL: begin
          dly_tx_sel <= 1'b1;
          dly_rx_sel <= 1'b1;
          st         <= ST_WOPEN;
        end
        ST_WOPEN: begin
          itap_win <= 1'b1;
          st       <= ST_IWR;
        end
        ST_IWR: begin
          itap_sel <= itap_q;
          st       <= ST_WCLOSE;
        end
        ST_WCLOSE: begin
          itap_win <= 1'b0;
          st       <= ST_CBUF;
        end
        ST_CBUF: begin
          clkbuf_sel <= cbuf_q;
          done       <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_dll_off_first_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start) |=> (!dll_en && $stable(otap_sel) && $stable(clkbuf_sel)));
  p_dll_not_with_chain_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dll_en) |-> (!dly_tx_sel && !dly_rx_sel));
  p_itap_in_window_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(itap_sel) |-> itap_win);
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && start && st != ST_CBUF && st != ST_WAIT) |=> busy);
endmodule

// File: tb/test_dlyphy_seq.sv
module test_dlyphy_seq;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [9:0] mhz = '0;
  logic [3:0] otap = '0;
  logic [4:0] itap = '0;
  logic [7:0] strb = '0;
  logic [3:0] trim = '0;
  logic [2:0] drv = '0;
  logic [2:0] cbuf = '0;
  logic ready = 1'b0;

  logic a_busy, a_done, a_err, a_oten, a_dll, a_s50, a_s100, a_tx, a_rx, a_win;
  logic [3:0] a_osel, a_trim;
  logic [3:0] a_strb;
  logic [2:0] a_code, a_drv, a_cbuf;
  logic [4:0] a_itap;
  logic b_busy, b_done, b_err, b_oten, b_dll, b_s50, b_s100, b_tx, b_rx, b_win;
  logic [3:0] b_osel, b_trim;
  logic [7:0] b_strb;
  logic [2:0] b_code, b_drv, b_cbuf;
  logic [4:0] b_itap;

  always #10 clk = ~clk;

  dlyphy_seq #(.FREQ_2BIT(1), .STRB_W(4), .TIMEOUT_CYC(TO)) i_dlyphy_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .clk_mhz(mhz),
    .otap_in(otap), .itap_in(itap), .strobe_in(strb[3:0]), .trim_in(trim),
    .drive_in(drv), .clkbuf_in(cbuf), .dll_ready(ready),
    .busy(a_busy), .done(a_done), .err(a_err), .otap_en(a_oten),
    .otap_sel(a_osel), .strobe_sel(a_strb), .dll_en(a_dll),
    .freq_sel50(a_s50), .freq_sel100(a_s100), .freq_code(a_code),
    .dll_trim(a_trim), .drive_str(a_drv), .dly_tx_sel(a_tx),
    .dly_rx_sel(a_rx), .itap_win(a_win), .itap_sel(a_itap), .clkbuf_sel(a_cbuf)
  );

  dlyphy_seq #(.FREQ_2BIT(0), .STRB_W(8), .TIMEOUT_CYC(TO)) i_dlyphy_seq_b (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .clk_mhz(mhz),
    .otap_in(otap), .itap_in(itap), .strobe_in(strb), .trim_in(trim),
    .drive_in(drv), .clkbuf_in(cbuf), .dll_ready(ready),
    .busy(b_busy), .done(b_done), .err(b_err), .otap_en(b_oten),
    .otap_sel(b_osel), .strobe_sel(b_strb), .dll_en(b_dll),
    .freq_sel50(b_s50), .freq_sel100(b_s100), .freq_code(b_code),
    .dll_trim(b_trim), .drive_str(b_drv), .dly_tx_sel(b_tx),
    .dly_rx_sel(b_rx), .itap_win(b_win), .itap_sel(b_itap), .clkbuf_sel(b_cbuf)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: a step counter plus expected output values.
  int m_step = 0;
  int m_wait = 0;
  bit m_dllpath = 0;
  int l_mode = 0, l_mhz = 0, l_otap = 0, l_itap = 0, l_strb = 0;
  int l_trim = 0, l_drv = 0, l_cbuf = 0;
  int e_oten = 0, e_osel = 0, e_strb = 0, e_dll = 0, e_s50 = 0, e_s100 = 0;
  int e_code = 0, e_trim = 0, e_drv = 0, e_tx = 0, e_rx = 0, e_win = 0;
  int e_itap = 0, e_cbuf = 0, e_done = 0, e_err = 0;

  always @(posedge clk) begin
    e_done = 0;
    e_err  = 0;
    if (rst) begin
      m_step = 0; m_wait = 0;
      e_oten = 0; e_osel = 0; e_strb = 0; e_dll = 0; e_s50 = 0; e_s100 = 0;
      e_code = 0; e_trim = 0; e_drv = 0; e_tx = 0; e_rx = 0; e_win = 0;
      e_itap = 0; e_cbuf = 0;
    end else begin
      case (m_step)
        0: if (start) begin
          l_mode = mode; l_mhz = mhz; l_otap = otap; l_itap = itap;
          l_strb = strb; l_trim = trim; l_drv = drv; l_cbuf = cbuf;
          e_dll = 0;
          m_step = 1;
        end
        1: begin
          e_oten = (l_mode > 4) ? 1 : 0;
          e_osel = l_otap;
          if (l_mode == 10) e_strb = l_strb;
          m_dllpath = (l_mode > 4) && (l_mhz >= 50);
          m_step = m_dllpath ? 10 : 20;
        end
        10: begin e_tx = 0; e_rx = 0; m_step = 11; end
        11: begin
          e_s50  = (l_mhz == 200 || l_mhz == 100) ? 0 : 1;
          e_s100 = (l_mhz == 100) ? 1 : 0;
          e_code = (l_mhz == 200) ? 0 : 4;
          m_step = 12;
        end
        12: begin e_trim = l_trim; e_drv = l_drv; m_step = 13; end
        13: begin e_dll = 1; m_wait = 0; m_step = 14; end
        14: begin
          if (ready) m_step = 30;
          else if (m_wait == TO - 1) begin e_err = 1; m_step = 0; end
          else m_wait++;
        end
        20: begin e_tx = 1; e_rx = 1; m_step = 21; end
        21: begin e_win = 1; m_step = 22; end
        22: begin e_itap = l_itap; m_step = 23; end
        23: begin e_win = 0; m_step = 30; end
        30: begin e_cbuf = l_cbuf; e_done = 1; m_step = 0; end
        default: m_step = 0;
      endcase
    end
  end

  bit armed = 0;
  int lock_delay = 2;
  int lock_cnt = 0;
  int n_done = 0, n_err = 0;

  always @(negedge clk) begin
    if (armed) begin
      chk("R12", "busy", a_busy, (m_step != 0) ? 1 : 0);
      chk("R11", "done", a_done, e_done);
      chk("R8",  "err", a_err, e_err);
      chk("R3",  "otap_en", a_oten, e_oten);
      chk("R3",  "otap_sel", a_osel, e_osel);
      chk("R10", "strobe4", a_strb, e_strb & 15);
      chk("R2",  "dll_en", a_dll, e_dll);
      chk("R6",  "sel50", a_s50, e_s50);
      chk("R6",  "sel100", a_s100, e_s100);
      chk("R6",  "code_2bit", a_code, 0);
      chk("R5",  "trim", a_trim, e_trim);
      chk("R5",  "drive", a_drv, e_drv);
      chk("R4",  "tx_sel", a_tx, e_tx);
      chk("R4",  "rx_sel", a_rx, e_rx);
      chk("R9",  "itap_win", a_win, e_win);
      chk("R9",  "itap_sel", a_itap, e_itap);
      chk("R11", "clkbuf", a_cbuf, e_cbuf);
      chk("R7",  "code_3bit", b_code, e_code);
      chk("R7",  "sel50_3bit", b_s50, 0);
      chk("R7",  "sel100_3bit", b_s100, 0);
      chk("R10", "strobe8", b_strb, e_strb);
      chk("R8",  "err_b", b_err, e_err);
      chk("R11", "done_b", b_done, e_done);
      chk("R2",  "dll_en_b", b_dll, e_dll);
      if (a_done) n_done++;
      if (a_err) n_err++;
    end
    if (!a_dll) begin lock_cnt = 0; ready = 1'b0; end
    else begin
      lock_cnt++;
      ready = (lock_delay >= 0 && lock_cnt >= lock_delay);
    end
  end

  task automatic run_seq(input int md, input int fm, input int ld, input int ot,
                         input int it, input int sb, input bit expect_ok);
    int d0, e0;
    d0 = n_done; e0 = n_err;
    @(negedge clk);
    lock_delay = ld;
    mode = 4'(md); mhz = 10'(fm); otap = 4'(ot); itap = 5'(it); strb = 8'(sb);
    trim = 4'(ot + 3); drv = 3'(it); cbuf = 3'(ot + it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && m_step != 0; k++) @(negedge clk);
    @(negedge clk);
    chk(expect_ok ? "R11" : "R8", "done count", n_done - d0, expect_ok ? 1 : 0);
    chk("R8", "err count", n_err - e0, expect_ok ? 0 : 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy at reset", a_busy, 0);
    chk("R1", "dll_en at reset", a_dll, 0);
    chk("R1", "clkbuf at reset", a_cbuf, 0);
    chk("R1", "itap at reset", a_itap, 0);
    armed = 1;
    rst = 1'b0;
    run_seq(9, 200, 3, 5, 7, 8'hA5, 1);   // R6 200 MHz, DLL path
    run_seq(6, 100, 1, 6, 9, 8'h11, 1);   // R6 100 MHz
    run_seq(5, 50, 0, 2, 3, 8'h22, 1);    // R4 boundary 50 MHz takes DLL
    run_seq(5, 49, 2, 9, 17, 8'h33, 1);   // R4 49 MHz takes chain
    run_seq(4, 200, 2, 3, 21, 8'h44, 1);  // R3 slow mode, chain, otap off
    run_seq(10, 200, 4, 12, 4, 8'hC7, 1); // R10 strobe mode
    run_seq(0, 25, 2, 1, 31, 8'h55, 1);   // R9 legacy chain
    run_seq(8, 52, -1, 7, 2, 8'h66, 0);   // R8 lock never comes
    run_seq(7, 50, TO - 1, 4, 5, 8'h77, 1); // R8 lock just before timeout
    // R12: second start during a running sequence is ignored
    @(negedge clk);
    lock_delay = 2;
    mode = 4'd0; mhz = 10'd10; otap = 4'd3; itap = 5'd6; cbuf = 3'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mode = 4'd9; mhz = 10'd200; itap = 5'd30; cbuf = 3'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 50 && m_step != 0; k++) @(negedge clk);
    @(negedge clk);
    chk("R12", "itap kept from first start", a_itap, 6);
    chk("R12", "clkbuf kept from first start", a_cbuf, 5);
    chk("R12", "dll stays off", a_dll, 0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule